// File: doc/BRIEF.md
# Descriptor-Chained Bus-Master DMA Engine

This block is the bus-master data mover of a storage host interface. Software builds a table of two-word entries in system memory, each naming a physical buffer and its byte count. It loads the table's base into a register and sets the run bit. The engine then walks the table entry by entry. It moves 32-bit words between memory and the device data FIFO in the selected direction, and it stops after the entry that carries the end marker.

Control, status and interrupt enable sit in a small 32-bit register file, so the block can sit behind any simple register bus. A single memory master port handles both the descriptor fetches and the data beats. Each request is held until the memory acknowledges it. The device side uses a valid/pop handshake for incoming words and a ready/push handshake for outgoing words. Three event inputs from the surrounding host logic are latched as sticky status bits. A single level interrupt reports any status bit whose enable bit is set.

Top module: `dmae_top`

## Requirements
- R1: After reset, the control, status, interrupt-enable and table-base registers (word offsets 0, 1, 2, 3) all read zero, `irq` is low and no memory request is made.
- R2: Entry n of the table sits at base + 8n; the low 3 base bits are ignored. Word 0 holds the buffer address, with bits 1:0 ignored for data. Word 1 holds the byte count in bits 28:0. An entry moves ceil(count/4) words at consecutive word addresses. A memory request holds its address and write flag until it is acknowledged.
- R3: With control bit 2 clear, each word is read from memory and pushed to the device FIFO, in table order.
- R4: With control bit 2 set, each word is popped from the device FIFO and written to memory, in table order.
- R5: With control bit 11 set, bit 0 of word 0 marks the last entry and word 1 bit 31 is ignored. With bit 11 clear, word 1 bit 31 marks the last entry and word 0 bit 0 is ignored.
- R6: Each entry that completes sets status bit 6. When the last entry completes, START (control bit 0) and ACT (status bit 0) clear and status bit 1 sets.
- R7: An entry with a zero count completes without any data beat.
- R8: A control write with bit 1 set while START is set ends the transfer. START and ACT clear, status bit 1 is not set, and no further memory request or device handshake is made.
- R9: While control bit 7 is set, all status bits read zero, event inputs are not latched, and a write setting START is ignored. The mode bits (2, 3, 11, 16) remain writable and readable.
- R10: Setting START with control bit 3 clear sets status bit 2 (error), leaves START clear and fetches nothing.
- R11: `irq` is high exactly when some status bit and the same interrupt-enable bit are both set. Writing 1 to a status bit clears it.
- R12: A one-cycle pulse on `dev_irq`, `dev_term` or `link_irq` sets status bit 4, 5 or 11 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 2 | Register word offset |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Level interrupt |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid with it |
| mem_rdata | input | 32 | Memory read data |
| dev_rd_valid | input | 1 | Device FIFO has a word for memory |
| dev_rd_data | input | 32 | Device FIFO word for memory |
| dev_rd_pop | output | 1 | Takes the device word this cycle |
| dev_wr_ready | input | 1 | Device FIFO can accept a word |
| dev_wr_data | output | 32 | Word for the device FIFO |
| dev_wr_push | output | 1 | Delivers the device word this cycle |
| dev_irq | input | 1 | Device interrupt event |
| dev_term | input | 1 | Device termination event |
| link_irq | input | 1 | Serial-link interrupt event |

## Verification
The bench builds the block with the default 29-bit count field. With that width, a 5-byte entry exercises the round-up to two words, and word 1 bits 29 to 31 are free to carry the alternate end marker. A word-0 address with bit 0 set tests that this bit is ignored in the other mode, and a marker in bit 31 tests the same the other way round. A 256-byte entry keeps the engine busy long enough to stop it mid-transfer. The device sink is ready only three cycles in four, so a push must wait for ready.

// File: rtl/dmae_pkg.sv
// dmae_pkg: shared field positions, register offsets and state encoding
// for the descriptor DMA engine. Assumes a 32-bit register interface.
package dmae_pkg;
    localparam int AW = 32;
    localparam int SW = 12;

    localparam int CTL_START = 0;
    localparam int CTL_STOP  = 1;
    localparam int CTL_DIR   = 2;
    localparam int CTL_DESC  = 3;
    localparam int CTL_HOLD  = 7;
    localparam int CTL_TBL32 = 11;
    localparam int CTL_ISM   = 16;

    localparam int ST_ACT    = 0;
    localparam int ST_NEND   = 1;
    localparam int ST_ERR    = 2;
    localparam int ST_DEVINT = 4;
    localparam int ST_DEVTRM = 5;
    localparam int ST_DNEND  = 6;
    localparam int ST_LINK   = 11;

    localparam logic [SW-1:0] ST_STICKY_MASK = 12'b1000_0111_0110;

    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_STAT = 2'd1,
        RA_IEN  = 2'd2,
        RA_BASE = 2'd3
    } reg_addr_e;

    typedef enum logic [2:0] {
        W_IDLE, W_FA, W_FL, W_GET, W_PUT, W_END
    } walk_e;
endpackage

// File: rtl/dmae_desc_decode.sv
// dmae_desc_decode: splits a fetched two-word entry into buffer address,
// word-beat count (rounded up) and the end marker for the selected table mode.
// Assumes word 0 is the address word and word 1 the count word.
module dmae_desc_decode
    import dmae_pkg::*;
#(
    parameter int LEN_W = 29,
    localparam int BC_W = LEN_W - 1
) (
    input  logic [31:0]   w0,
    input  logic [31:0]   w1,
    input  logic          tbl32,
    output logic [AW-1:0] data_addr,
    output logic [BC_W-1:0] beats,
    output logic          last
);
    logic [LEN_W:0] padded;
    logic           unused_bits;

    // round the byte count up to whole words
    assign padded      = {1'b0, w1[LEN_W-1:0]} + (LEN_W+1)'(3);
    assign beats       = padded[LEN_W:2];
    // data is word aligned; low address bits carry no data meaning
    assign data_addr   = {w0[AW-1:2], 2'b00};
    // end marker location depends on table mode
    assign last        = tbl32 ? w0[0] : w1[31];
    assign unused_bits = ^{w0[1], w1[31:LEN_W]};
endmodule

// File: rtl/dmae_regs.sv
// dmae_regs: control, status, interrupt-enable and table-base registers.
// Turns control writes into go/kill pulses for the walker, latches sticky
// status events and forms the level interrupt. Assumes one write per cycle.
module dmae_regs
    import dmae_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_wr,
    input  logic [1:0]    cpu_addr,
    input  logic [31:0]   cpu_wdata,
    output logic [31:0]   cpu_rdata,
    output logic [AW-1:0] base_o,
    output logic          dir_o,
    output logic          tbl32_o,
    output logic          hold_o,
    output logic          go_o,
    output logic          kill_o,
    output logic          start_o,
    output logic [SW-1:0] sts_o,
    input  logic          desc_done_i,
    input  logic          table_done_i,
    input  logic          dev_irq_i,
    input  logic          dev_term_i,
    input  logic          link_irq_i,
    output logic          irq_o
);
    logic          start_q, dir_q, desc_q, hold_q, tbl32_q, ism_q;
    logic [SW-1:0] sts_q, ien_q, set_v, clr_v, view_v;
    logic [AW-1:0] base_q;
    logic          wr_ctl, wr_stat, try_start, bad_start;

    // decode register writes
    assign wr_ctl    = cpu_wr && (cpu_addr == RA_CTRL);
    assign wr_stat   = cpu_wr && (cpu_addr == RA_STAT);
    assign kill_o    = wr_ctl && start_q && (cpu_wdata[CTL_STOP] || cpu_wdata[CTL_HOLD]);
    assign try_start = wr_ctl && !start_q && cpu_wdata[CTL_START] && !cpu_wdata[CTL_STOP]
                       && !cpu_wdata[CTL_HOLD] && !hold_q;
    assign go_o      = try_start && cpu_wdata[CTL_DESC];
    assign bad_start = try_start && !cpu_wdata[CTL_DESC];

    // mode values seen by the walker at the go edge include the same write
    assign dir_o   = wr_ctl ? cpu_wdata[CTL_DIR]   : dir_q;
    assign tbl32_o = wr_ctl ? cpu_wdata[CTL_TBL32] : tbl32_q;
    assign hold_o  = hold_q;
    assign start_o = start_q;
    assign base_o  = base_q;
    assign sts_o   = sts_q;

    // control register: mode bits and the run bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0; dir_q <= 1'b0; desc_q <= 1'b0;
            hold_q  <= 1'b0; tbl32_q <= 1'b0; ism_q <= 1'b0;
        end else begin
            if (wr_ctl) begin
                dir_q   <= cpu_wdata[CTL_DIR];
                desc_q  <= cpu_wdata[CTL_DESC];
                hold_q  <= cpu_wdata[CTL_HOLD];
                tbl32_q <= cpu_wdata[CTL_TBL32];
                ism_q   <= cpu_wdata[CTL_ISM];
            end
            if (kill_o)            start_q <= 1'b0;
            else if (go_o)         start_q <= 1'b1;
            else if (table_done_i) start_q <= 1'b0;
        end
    end

    // table base and interrupt-enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            ien_q  <= '0;
        end else if (cpu_wr) begin
            if (cpu_addr == RA_BASE) base_q <= cpu_wdata;
            if (cpu_addr == RA_IEN)  ien_q  <= cpu_wdata[SW-1:0];
        end
    end

    // collect status set events
    always_comb begin
        set_v              = '0;
        set_v[ST_NEND]     = table_done_i;
        set_v[ST_ERR]      = bad_start;
        set_v[ST_DEVINT]   = dev_irq_i;
        set_v[ST_DEVTRM]   = dev_term_i;
        set_v[ST_DNEND]    = desc_done_i;
        set_v[ST_LINK]     = link_irq_i;
    end
    assign clr_v = wr_stat ? cpu_wdata[SW-1:0] : '0;

    // sticky status: set wins over write-one-to-clear, hold clears all
    always_ff @(posedge clk) begin
        if (!rst_n || hold_q) sts_q <= '0;
        else                  sts_q <= ((sts_q & ~clr_v) | set_v) & ST_STICKY_MASK;
    end

    // status view with the live active bit, and the interrupt
    assign view_v = {sts_q[SW-1:1], start_q};
    assign irq_o  = |(view_v & ien_q);

    // register read mux
    always_comb begin
        cpu_rdata = '0;
        unique case (cpu_addr)
            RA_CTRL: begin
                cpu_rdata[CTL_START] = start_q;
                cpu_rdata[CTL_DIR]   = dir_q;
                cpu_rdata[CTL_DESC]  = desc_q;
                cpu_rdata[CTL_HOLD]  = hold_q;
                cpu_rdata[CTL_TBL32] = tbl32_q;
                cpu_rdata[CTL_ISM]   = ism_q;
            end
            RA_STAT: cpu_rdata[SW-1:0] = view_v;
            RA_IEN:  cpu_rdata[SW-1:0] = ien_q;
            default: cpu_rdata = base_q;
        endcase
    end
endmodule

// File: rtl/dmae_walker.sv
// dmae_walker: fetches entries from the table, counts down word beats and
// moves each word between memory and the device FIFO. Assumes the memory
// returns read data together with its acknowledge and that a dropped request
// (on kill) may simply be abandoned.
module dmae_walker
    import dmae_pkg::*;
#(
    parameter int LEN_W = 29,
    localparam int BC_W = LEN_W - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic          kill_i,
    input  logic          hold_i,
    input  logic          dir_i,
    input  logic          tbl32_i,
    input  logic [AW-1:0] base_i,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    input  logic          dev_rd_valid,
    input  logic [31:0]   dev_rd_data,
    output logic          dev_rd_pop,
    input  logic          dev_wr_ready,
    output logic [31:0]   dev_wr_data,
    output logic          dev_wr_push,
    output logic          desc_done_o,
    output logic          table_done_o
);
    walk_e           state;
    logic [AW-1:0]   ptr, daddr, dec_addr;
    logic [31:0]     w0_q, dword;
    logic [BC_W-1:0] beats, dec_beats;
    logic            last_q, dir_q, tbl_q, dec_last, put_fire;
    logic            unused_base;

    dmae_desc_decode #(.LEN_W(LEN_W)) u_dec (
        .w0(w0_q), .w1(mem_rdata), .tbl32(tbl_q),
        .data_addr(dec_addr), .beats(dec_beats), .last(dec_last)
    );

    assign unused_base = ^base_i[2:0];
    assign put_fire    = dir_q ? mem_ack : dev_wr_ready;

    // walk the table one state per step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= W_IDLE; ptr <= '0; daddr <= '0; w0_q <= '0; dword <= '0;
            beats <= '0; last_q <= 1'b0; dir_q <= 1'b0; tbl_q <= 1'b0;
        end else if (kill_i || hold_i) begin
            state <= W_IDLE;
        end else begin
            unique case (state)
                W_IDLE: if (go_i) begin
                    ptr   <= {base_i[AW-1:3], 3'b000};
                    dir_q <= dir_i;
                    tbl_q <= tbl32_i;
                    state <= W_FA;
                end
                W_FA: if (mem_ack) begin
                    w0_q  <= mem_rdata;
                    state <= W_FL;
                end
                W_FL: if (mem_ack) begin
                    daddr  <= dec_addr;
                    beats  <= dec_beats;
                    last_q <= dec_last;
                    ptr    <= ptr + AW'(8);
                    state  <= (dec_beats == '0) ? W_END : W_GET;
                end
                W_GET: if (dir_q) begin
                    if (dev_rd_valid) begin
                        dword <= dev_rd_data;
                        state <= W_PUT;
                    end
                end else if (mem_ack) begin
                    dword <= mem_rdata;
                    state <= W_PUT;
                end
                W_PUT: if (put_fire) begin
                    daddr <= daddr + AW'(4);
                    beats <= beats - BC_W'(1);
                    state <= (beats == BC_W'(1)) ? W_END : W_GET;
                end
                W_END:   state <= last_q ? W_IDLE : W_FA;
                default: state <= W_IDLE;
            endcase
        end
    end

    // memory master request and address selection
    always_comb begin
        mem_req  = (state == W_FA) || (state == W_FL) ||
                   (state == W_GET && !dir_q) || (state == W_PUT && dir_q);
        mem_we   = (state == W_PUT) && dir_q;
        unique case (state)
            W_FA:    mem_addr = ptr;
            W_FL:    mem_addr = ptr + AW'(4);
            default: mem_addr = daddr;
        endcase
    end
    assign mem_wdata = dword;

    // device FIFO handshakes and completion pulses
    assign dev_rd_pop   = (state == W_GET) && dir_q && dev_rd_valid;
    assign dev_wr_push  = (state == W_PUT) && !dir_q && dev_wr_ready;
    assign dev_wr_data  = dword;
    assign desc_done_o  = (state == W_END);
    assign table_done_o = (state == W_END) && last_q;
endmodule

// File: rtl/dmae_top.sv
// dmae_top: descriptor-chained bus-master DMA engine. Joins the register
// file and the table walker. Assumes a single clock and synchronous reset.
module dmae_top
    import dmae_pkg::*;
#(
    parameter int LEN_W = 29
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_wr,
    input  logic [1:0]    cpu_addr,
    input  logic [31:0]   cpu_wdata,
    output logic [31:0]   cpu_rdata,
    output logic          irq,
    output logic          mem_req,
    output logic          mem_we,
    output logic [31:0]   mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    input  logic          dev_rd_valid,
    input  logic [31:0]   dev_rd_data,
    output logic          dev_rd_pop,
    input  logic          dev_wr_ready,
    output logic [31:0]   dev_wr_data,
    output logic          dev_wr_push,
    input  logic          dev_irq,
    input  logic          dev_term,
    input  logic          link_irq
);
    logic [AW-1:0] base_w;
    logic [SW-1:0] sts_w;
    logic dir_w, tbl32_w, hold_w, go_w, kill_w, start_w, desc_done_w, table_done_w;

    dmae_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .base_o(base_w),
        .dir_o(dir_w), .tbl32_o(tbl32_w), .hold_o(hold_w), .go_o(go_w),
        .kill_o(kill_w), .start_o(start_w), .sts_o(sts_w),
        .desc_done_i(desc_done_w), .table_done_i(table_done_w),
        .dev_irq_i(dev_irq), .dev_term_i(dev_term), .link_irq_i(link_irq),
        .irq_o(irq)
    );

    dmae_walker #(.LEN_W(LEN_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .go_i(go_w), .kill_i(kill_w), .hold_i(hold_w),
        .dir_i(dir_w), .tbl32_i(tbl32_w), .base_i(base_w),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .dev_rd_valid(dev_rd_valid), .dev_rd_data(dev_rd_data), .dev_rd_pop(dev_rd_pop),
        .dev_wr_ready(dev_wr_ready), .dev_wr_data(dev_wr_data), .dev_wr_push(dev_wr_push),
        .desc_done_o(desc_done_w), .table_done_o(table_done_w)
    );
endmodule

// File: rtl/dmae_top_chk.sv
// dmae_top_chk: protocol and status properties of the DMA engine, bound
// to dmae_top. Observes ports and the register/walker interface nets.
module dmae_top_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_ack,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic        dev_rd_pop,
    input logic        dev_wr_push,
    input logic        start_w,
    input logic        kill_w,
    input logic        hold_w,
    input logic        table_done_w,
    input logic [11:0] sts_w
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack && !kill_w |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !start_w |-> !mem_req && !dev_rd_pop && !dev_wr_push); // R8
    AST_DONE_NEND: assert property (@(posedge clk) disable iff (!rst_n)
        table_done_w && !kill_w |=> sts_w[1] && !start_w); // R6
    AST_HOLD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        hold_w |=> sts_w == 12'd0); // R9
    AST_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_rd_pop && dev_wr_push)); // R3
endmodule

bind dmae_top dmae_top_chk chk_i (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_we(mem_we), .mem_addr(mem_addr), .dev_rd_pop(dev_rd_pop),
    .dev_wr_push(dev_wr_push), .start_w(start_w), .kill_w(kill_w),
    .hold_w(hold_w), .table_done_w(table_done_w), .sts_w(sts_w)
);

// File: tb/dmae_top_tb_top.sv
// Scoreboard bench: tasks queue expected memory writes and device pushes,
// a negedge monitor pops and compares as the engine produces them.
module dmae_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [1:0]  cpu_addr = 2'd0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        irq, mem_req, mem_we, dev_rd_pop, dev_wr_push;
    logic [31:0] mem_addr, mem_wdata, dev_wr_data;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        dev_rd_valid = 1'b1;
    logic [31:0] src_cnt = 32'hD000_0000;
    logic [3:0]  snk_cnt = '0;
    logic        dev_wr_ready;
    logic        dev_irq = 1'b0, dev_term = 1'b0, link_irq = 1'b0;

    logic [31:0] mem [0:255];
    logic [63:0] exp_q [$];
    int n_cmp = 0, n_bad = 0, req_seen = 0, push_seen = 0;
    bit sb_on = 1'b0, done = 1'b0;

    always #10 clk = ~clk;

    dmae_top dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .dev_rd_valid(dev_rd_valid), .dev_rd_data(src_cnt), .dev_rd_pop(dev_rd_pop),
        .dev_wr_ready(dev_wr_ready), .dev_wr_data(dev_wr_data), .dev_wr_push(dev_wr_push),
        .dev_irq(dev_irq), .dev_term(dev_term), .link_irq(link_irq)
    );

    // memory model: acknowledge one cycle after a request
    always @(posedge clk) begin
        mem_ack <= mem_req && !mem_ack;
        if (mem_req && !mem_ack) begin
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            mem_rdata <= mem[mem_addr[9:2]];
        end
    end

    // device source and stalling sink
    always @(posedge clk) begin
        if (dev_rd_pop) src_cnt <= src_cnt + 1;
        snk_cnt <= snk_cnt + 1;
    end
    assign dev_wr_ready = (snk_cnt[1:0] != 2'd3);

    task automatic compare(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compare produced items against the scoreboard queue
    always @(negedge clk) begin
        if (mem_req) req_seen++;
        if (dev_wr_push) push_seen++;
        if (sb_on) begin
            if (dev_wr_push) begin
                if (exp_q.size() == 0) compare("R3 unexpected push", {32'hFFFF_FFFF, dev_wr_data}, 64'd0);
                else compare("R3 device push", {32'hFFFF_FFFF, dev_wr_data}, exp_q.pop_front());
            end
            if (mem_req && mem_we && !mem_ack) begin
                if (exp_q.size() == 0) compare("R4 unexpected write", {mem_addr, mem_wdata}, 64'd0);
                else compare("R4 memory write", {mem_addr, mem_wdata}, exp_q.pop_front());
            end
        end
    end

    task automatic cpu_write(logic [1:0] a, logic [31:0] d);
        @(negedge clk); cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk); cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(logic [1:0] a, output logic [31:0] d);
        @(negedge clk); cpu_addr = a; #1; d = cpu_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            cpu_read(2'd1, s);
            if (!s[0]) break;
        end
    endtask

    task automatic pulse(int which);
        @(negedge clk);
        if (which == 0) dev_irq = 1'b1; else if (which == 1) dev_term = 1'b1; else link_irq = 1'b1;
        @(negedge clk);
        dev_irq = 1'b0; dev_term = 1'b0; link_irq = 1'b0;
    endtask

    task automatic put(logic [31:0] a, logic [31:0] d);
        mem[a[9:2]] = d;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        for (int i = 0; i < 256; i++) mem[i] = 32'h5EED_0000 | i;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            cpu_read(a[1:0], r);
            compare("R1 register after reset", {32'd0, r}, 64'd0);
        end
        compare("R1 irq/mem_req after reset", {62'd0, irq, mem_req}, 64'd0);

        // R2 R3 R5 R6: memory to device, end flag in word 0 bit 0; word 1 bit 31 ignored
        put(32'h000, 32'h0000_0100); put(32'h004, 32'h8000_0008);
        put(32'h008, 32'h0000_0201); put(32'h00C, 32'h0000_0005);
        exp_q.push_back({32'hFFFF_FFFF, mem[32'h100 >> 2]});
        exp_q.push_back({32'hFFFF_FFFF, mem[32'h104 >> 2]});
        exp_q.push_back({32'hFFFF_FFFF, mem[32'h200 >> 2]});
        exp_q.push_back({32'hFFFF_FFFF, mem[32'h204 >> 2]});
        sb_on = 1'b1;
        cpu_write(2'd3, 32'h0000_0000);
        cpu_write(2'd2, 32'h0000_0002);
        cpu_write(2'd0, 32'h0000_0809);
        wait_idle();
        compare("R2 R5 all words delivered", {32'd0, 32'(exp_q.size())}, 64'd0);
        cpu_read(2'd1, r);
        compare("R6 status after table", {32'd0, r}, {32'd0, 32'h0000_0042});
        cpu_read(2'd0, r);
        compare("R6 START cleared", {63'd0, r[0]}, 64'd0);
        compare("R11 irq on enabled end", {63'd0, irq}, 64'd1);
        cpu_write(2'd1, 32'h0000_0042);
        cpu_read(2'd1, r);
        compare("R11 write-one-to-clear", {32'd0, r}, 64'd0);
        compare("R11 irq after clear", {63'd0, irq}, 64'd0);

        // R4 R5 R7: device to memory, end flag in word 1 bit 31, zero-length entry
        put(32'h040, 32'h0000_0300); put(32'h044, 32'h0000_0000);
        put(32'h048, 32'h0000_0311); put(32'h04C, 32'h0000_000C);
        put(32'h050, 32'h0000_0340); put(32'h054, 32'h8000_0004);
        exp_q.push_back({32'h0000_0310, 32'hD000_0000});
        exp_q.push_back({32'h0000_0314, 32'hD000_0001});
        exp_q.push_back({32'h0000_0318, 32'hD000_0002});
        exp_q.push_back({32'h0000_0340, 32'hD000_0003});
        cpu_write(2'd3, 32'h0000_0040);
        cpu_write(2'd0, 32'h0000_000D);
        wait_idle();
        compare("R4 R5 all writes seen", {32'd0, 32'(exp_q.size())}, 64'd0);
        compare("R7 zero-length untouched", {32'd0, mem[32'h300 >> 2]}, {32'd0, 32'h5EED_00C0});
        cpu_read(2'd1, r);
        compare("R6 status after second table", {32'd0, r}, {32'd0, 32'h0000_0042});
        cpu_write(2'd1, 32'h0000_0FFF);
        sb_on = 1'b0;

        // R8: stop a long transfer
        put(32'h080, 32'h0000_0101); put(32'h084, 32'h0000_0100);
        cpu_write(2'd3, 32'h0000_0080);
        cpu_write(2'd0, 32'h0000_0809);
        repeat (30) @(negedge clk);
        cpu_write(2'd0, 32'h0000_080B);
        cpu_read(2'd0, r);
        compare("R8 START cleared by stop", {63'd0, r[0]}, 64'd0);
        cpu_read(2'd1, r);
        compare("R8 ACT and end clear", {62'd0, r[1:0]}, 64'd0);
        req_seen = 0; push_seen = 0;
        repeat (20) @(negedge clk);
        compare("R8 quiet after stop", {32'(req_seen), 32'(push_seen)}, 64'd0);
        cpu_write(2'd1, 32'h0000_0FFF);

        // R10: start without descriptor mode
        cpu_write(2'd0, 32'h0000_0001);
        req_seen = 0;
        repeat (10) @(negedge clk);
        cpu_read(2'd1, r);
        compare("R10 error status", {32'd0, r}, {32'd0, 32'h0000_0004});
        compare("R10 no fetch", {32'd0, 32'(req_seen)}, 64'd0);
        cpu_write(2'd1, 32'h0000_0FFF);

        // R9: hold bit
        cpu_write(2'd0, 32'h0001_0884);
        cpu_read(2'd0, r);
        compare("R9 modes writable in hold", {32'd0, r}, {32'd0, 32'h0001_0884});
        pulse(0);
        cpu_read(2'd1, r);
        compare("R9 status held clear", {32'd0, r}, 64'd0);
        cpu_write(2'd0, 32'h0000_0089);
        req_seen = 0;
        repeat (10) @(negedge clk);
        cpu_read(2'd0, r);
        compare("R9 start ignored in hold", {32'd0, r}, {32'd0, 32'h0000_0088});
        compare("R9 no fetch in hold", {32'd0, 32'(req_seen)}, 64'd0);
        cpu_write(2'd0, 32'h0000_0000);

        // R12 R11: event inputs and masking
        cpu_write(2'd2, 32'h0000_0010);
        pulse(0); pulse(1); pulse(2);
        cpu_read(2'd1, r);
        compare("R12 event bits", {32'd0, r}, {32'd0, 32'h0000_0830});
        compare("R11 irq from enabled event", {63'd0, irq}, 64'd1);
        cpu_write(2'd1, 32'h0000_0010);
        cpu_read(2'd1, r);
        compare("R11 partial clear", {32'd0, r}, {32'd0, 32'h0000_0820});
        compare("R11 irq masked bits", {63'd0, irq}, 64'd0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule